// File: doc/BRIEF.md
# Validity-Change Interrupt Unit

This block watches four reference-input validity flags and raises an interrupt whenever one of them changes state. Two of the flags belong to differential reference inputs and two to CMOS reference inputs. Each flag first passes through a synchronizer. Each flag has a sticky status bit, which is set on every transition of that flag in either direction. The bit stays set until software clears it by writing a one to it.

Software reaches the block through a byte-wide register port made of an address, a write strobe, write data and combinational read data. A configuration register selects the active level of the interrupt request. It also selects whether the request pin drives its inactive level or floats while nothing is pending. The block drives an output value and an output enable, so the pad outside can implement the tri-state.

Top module: `vld_irq_unit`

## Requirements
- R1: After reset the configuration register (address 0x0C) reads 0x02: bit 0 (polarity) is 0, meaning active low, and bit 1 (float-when-idle) is 1.
- R2: While an interrupt is pending, `irq_out` equals configuration bit 0: 1 for active high and 0 for active low.
- R3: While nothing is pending, `irq_oe` is 0 if configuration bit 1 is 1. If configuration bit 1 is 0, `irq_oe` is 1 and `irq_out` is the inverse of bit 0.
- R4: After reset the status register (address 0x0D) reads 0x3C, with all four change bits set.
- R5: A rising or a falling transition of a validity flag sets its status bit: bit 5 for `diff_vld[1]`, bit 4 for `diff_vld[0]`, bit 3 for `cmos_vld[1]` and bit 2 for `cmos_vld[0]`. The bit is not yet visible two clock edges after the flag changes and is visible after the third edge.
- R6: Writing a 1 to a status bit clears it. Writing a 0 leaves it unchanged.
- R7: When a transition and a write-one-to-clear reach the same status bit in the same cycle, the bit ends up set.
- R8: Bits 7..2 of the configuration register and bits 7..6 and 1..0 of the status register read as 0, and writes to them have no effect.
- R9: A read of any other address returns 0x00. A write to any other address changes no register.
- R10: An interrupt is pending exactly when any status bit is 1. While one is pending, `irq_oe` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Write strobe, sampled on the clock edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| diff_vld | input | 2 | Validity flags of the differential reference inputs (asynchronous) |
| cmos_vld | input | 2 | Validity flags of the CMOS reference inputs (asynchronous) |
| irq_out | output | 1 | Interrupt request value driven to the pad |
| irq_oe | output | 1 | Output enable of the interrupt pad |

## Verification
The assertions assume that the register port is synchronous to `clk`. They also assume that each validity flag holds each new value for at least one clock period, so that every change reaches the edge detector as a single pulse. The stimulus meets both assumptions: it changes addresses, strobes and flags only on the falling edge, and it holds every flag value for several cycles. The same-cycle collision of R7 is produced by timing the clear write so that it lands exactly on the edge where the synchronized transition reaches the status bit.

// File: rtl/vic_pkg.sv
package vic_pkg;

    // Configuration register contents (two live bits)
    typedef struct packed {
        logic float_idle;  // 1: pad released while nothing pending
        logic act_high;    // 1: active-high request
    } vic_cfg_t;

    localparam vic_cfg_t VIC_CFG_RESET = '{float_idle: 1'b1, act_high: 1'b0};

endpackage

// File: rtl/vic_sync.sv
module vic_sync #(
    parameter int NUM    = 4,
    parameter int STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NUM-1:0] flag_i,
    output logic [NUM-1:0] toggle_o
);

    typedef struct packed {
        logic [STAGES-1:0][NUM-1:0] pipe;
        logic [NUM-1:0]             prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.pipe[0] = flag_i;
        for (int s = 1; s < STAGES; s++) begin
            st_d.pipe[s] = st_q.pipe[s-1];
        end
        st_d.prev    = st_q.pipe[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign toggle_o = st_q.pipe[STAGES-1] ^ st_q.prev;

    // R5: a synchronized flag that has just changed produces a single-cycle toggle pulse
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (toggle_o != '0) |=> ((toggle_o & $past(toggle_o)) == '0 || $past(flag_i) != flag_i
                              || $past(st_q.pipe[0]) != st_q.pipe[0]));

endmodule

// File: rtl/vic_status.sv
module vic_status #(
    parameter int NUM = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NUM-1:0] set_i,
    input  logic [NUM-1:0] clr_i,
    output logic [NUM-1:0] sts_o
);

    typedef struct packed {
        logic [NUM-1:0] sticky;
    } sts_st_t;

    sts_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM; i++) begin
            if (set_i[i]) begin
                st_d.sticky[i] = 1'b1;          // set wins over clear
            end else if (clr_i[i]) begin
                st_d.sticky[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{sticky: '1};
        end else begin
            st_q <= st_d;
        end
    end

    assign sts_o = st_q.sticky;

    for (genvar g = 0; g < NUM; g++) begin : g_chk
        a_r5_toggle_sets: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[g] |=> sts_o[g]);
        a_r7_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (set_i[g] && clr_i[g]) |=> sts_o[g]);
        a_r6_clear_one: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[g] && !set_i[g]) |=> !sts_o[g]);
        a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_i[g] && !set_i[g]) |=> $stable(sts_o[g]));
    end

endmodule

// File: rtl/vic_regif.sv
module vic_regif
    import vic_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter int          DATA_W   = 8,
    parameter int          NUM      = 4,
    parameter int          STS_LSB  = 2,
    parameter logic [7:0]  CFG_ADDR = 8'h0C,
    parameter logic [7:0]  STS_ADDR = 8'h0D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [NUM-1:0]    sts_i,
    output vic_cfg_t          cfg_o,
    output logic [NUM-1:0]    clr_o,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int CFG_W = $bits(vic_cfg_t);

    typedef struct packed {
        vic_cfg_t cfg;
    } reg_st_t;

    reg_st_t st_d, st_q;
    logic    hit_cfg, hit_sts;
    logic    unused_wdata;

    assign hit_cfg      = (addr_i == ADDR_W'(CFG_ADDR));
    assign hit_sts      = (addr_i == ADDR_W'(STS_ADDR));
    assign unused_wdata = ^wdata_i;

    always_comb begin
        st_d = st_q;
        if (wr_i && hit_cfg) begin
            st_d.cfg = vic_cfg_t'(wdata_i[CFG_W-1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cfg: VIC_CFG_RESET};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        clr_o = '0;
        if (wr_i && hit_sts) begin
            clr_o = wdata_i[STS_LSB +: NUM];
        end
    end

    always_comb begin
        rdata_o = '0;
        if (hit_cfg) begin
            rdata_o[CFG_W-1:0] = st_q.cfg;
        end else if (hit_sts) begin
            rdata_o[STS_LSB +: NUM] = sts_i;
        end
    end

    assign cfg_o = st_q.cfg;

    // R8: a configuration write keeps only the live bits
    a_r8_cfg_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && hit_cfg) |=> (cfg_o == vic_cfg_t'($past(wdata_i[CFG_W-1:0]))));
    // R9: writes elsewhere leave the configuration alone
    a_r9_cfg_keep: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && hit_cfg) |=> $stable(cfg_o));

endmodule

// File: rtl/vic_pin.sv
module vic_pin
    import vic_pkg::*;
(
    input  vic_cfg_t cfg_i,
    input  logic     pending_i,
    output logic     out_o,
    output logic     oe_o
);

    always_comb begin
        out_o = pending_i ^ ~cfg_i.act_high;
        oe_o  = pending_i | ~cfg_i.float_idle;
    end

endmodule

// File: rtl/vld_irq_unit.sv
module vld_irq_unit
    import vic_pkg::*;
#(
    parameter int         NUM_DIFF    = 2,
    parameter int         NUM_CMOS    = 2,
    parameter int         SYNC_STAGES = 2,
    parameter int         STS_LSB     = 2,
    parameter logic [7:0] CFG_ADDR    = 8'h0C,
    parameter logic [7:0] STS_ADDR    = 8'h0D
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [7:0]          reg_addr,
    input  logic                reg_wr,
    input  logic [7:0]          reg_wdata,
    output logic [7:0]          reg_rdata,
    input  logic [NUM_DIFF-1:0] diff_vld,
    input  logic [NUM_CMOS-1:0] cmos_vld,
    output logic                irq_out,
    output logic                irq_oe
);

    localparam int NUM = NUM_DIFF + NUM_CMOS;

    logic [NUM-1:0] flags, toggles, clr, sts;
    vic_cfg_t       cfg;
    logic           pending;

    // CMOS flags occupy the low status bits, differential flags the high ones
    assign flags   = {diff_vld, cmos_vld};
    assign pending = |sts;

    vic_sync #(.NUM(NUM), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .flag_i   (flags),
        .toggle_o (toggles)
    );

    vic_status #(.NUM(NUM)) u_status (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (toggles),
        .clr_i (clr),
        .sts_o (sts)
    );

    vic_regif #(
        .ADDR_W   (8),
        .DATA_W   (8),
        .NUM      (NUM),
        .STS_LSB  (STS_LSB),
        .CFG_ADDR (CFG_ADDR),
        .STS_ADDR (STS_ADDR)
    ) u_regif (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (reg_addr),
        .wr_i    (reg_wr),
        .wdata_i (reg_wdata),
        .sts_i   (sts),
        .cfg_o   (cfg),
        .clr_o   (clr),
        .rdata_o (reg_rdata)
    );

    vic_pin u_pin (
        .cfg_i     (cfg),
        .pending_i (pending),
        .out_o     (irq_out),
        .oe_o      (irq_oe)
    );

    // R10 / R2: a set status bit drives the pad at the active level
    a_r10_pending_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (sts != '0) |-> (irq_oe && irq_out == cfg.act_high));
    // R3: idle pad either floats or drives the inactive level
    a_r3_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        (sts == '0 && irq_oe) |-> (irq_out != cfg.act_high));
    // R9: unmapped addresses read as zero
    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr != CFG_ADDR && reg_addr != STS_ADDR) |-> (reg_rdata == 8'h00));
    // R8: reserved status bits read zero
    a_r8_sts_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == STS_ADDR) |-> (reg_rdata[7:6] == 2'b00 && reg_rdata[1:0] == 2'b00));

endmodule

// File: tb/test_vld_irq_unit.sv
`timescale 1ns/1ps
module test_vld_irq_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [1:0] diff_vld = 2'b00;
    logic [1:0] cmos_vld = 2'b00;
    logic       irq_out, irq_oe;

    always #2 clk = ~clk;   // 250 MHz

    vld_irq_unit i_vld_irq_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .diff_vld  (diff_vld),
        .cmos_vld  (cmos_vld),
        .irq_out   (irq_out),
        .irq_oe    (irq_oe)
    );

    // scoreboard item: kind 0 = read data, 1 = irq_out, 2 = irq_oe
    typedef struct {
        int    kind;
        int    exp;
        string req;
    } sb_item_t;

    sb_item_t sb_q[$];
    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // monitor: compares every queued expectation against the ports
    initial begin
        forever begin
            wait (sb_q.size() != 0);
            #1;
            while (sb_q.size() != 0) begin
                sb_item_t it;
                int act;
                it = sb_q.pop_front();
                case (it.kind)
                    0:       act = int'(reg_rdata);
                    1:       act = int'(irq_out);
                    default: act = int'(irq_oe);
                endcase
                n_checks++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s kind=%0d actual=0x%0h expected=0x%0h", it.req, it.kind, act, it.exp);
                end
            end
        end
    end

    task automatic push(int kind, int exp, string req);
        sb_item_t it;
        it.kind = kind;
        it.exp  = exp;
        it.req  = req;
        sb_q.push_back(it);
    endtask

    task automatic exp_read(logic [7:0] a, int exp, string req);
        @(negedge clk);
        reg_addr = a;
        push(0, exp, req);
        wait (sb_q.size() == 0);
        #1;
    endtask

    task automatic exp_pin(int o, int oe, string req);
        @(negedge clk);
        push(1, o, req);
        push(2, oe, req);
        wait (sb_q.size() == 0);
        #1;
    endtask

    task automatic write(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    // change one flag (0..1 cmos, 2..3 diff) and wait until its bit is visible
    task automatic flip(int idx);
        @(negedge clk);
        if (idx < 2) cmos_vld[idx] = ~cmos_vld[idx];
        else         diff_vld[idx-2] = ~diff_vld[idx-2];
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        exp_read(8'h0C, 8'h02, "R1 cfg reset");
        exp_read(8'h0D, 8'h3C, "R4 status reset");
        exp_pin(0, 1, "R10 pending after reset, active low");

        // clear everything
        write(8'h0D, 8'hFF);
        exp_read(8'h0D, 8'h00, "R6 clear all / R8 reserved");
        exp_pin(1, 0, "R3 idle floats (oe=0)");

        // configuration reserved bits and modes
        write(8'h0C, 8'hFF);
        exp_read(8'h0C, 8'h03, "R8 cfg reserved bits");
        write(8'h0C, 8'h00);
        exp_pin(1, 1, "R3 idle drives high when active low");
        write(8'h0C, 8'h01);
        exp_pin(0, 1, "R3 idle drives low when active high");

        // R5 latency: rising diff_vld[1]
        @(negedge clk);
        diff_vld[1] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        push(0, 8'h00, "R5 not visible after two edges");
        reg_addr = 8'h0D;
        wait (sb_q.size() == 0);
        #1;
        exp_read(8'h0D, 8'h20, "R5 rising diff2 after three edges");
        exp_pin(1, 1, "R2 active high pending");

        // R6 write zero keeps, write one clears
        write(8'h0D, 8'h00);
        exp_read(8'h0D, 8'h20, "R6 write zero keeps");
        write(8'h0D, 8'h20);
        exp_read(8'h0D, 8'h00, "R6 write one clears");

        // falling edge
        flip(3);
        exp_read(8'h0D, 8'h20, "R5 falling diff2");
        write(8'h0D, 8'h20);

        // remaining inputs, accumulating
        flip(0);
        exp_read(8'h0D, 8'h04, "R5 cmos1 bit2");
        flip(2);
        exp_read(8'h0D, 8'h14, "R5 diff1 bit4");
        flip(1);
        exp_read(8'h0D, 8'h1C, "R5 cmos2 bit3");
        write(8'h0D, 8'h10);
        exp_read(8'h0D, 8'h0C, "R6 selective clear");
        write(8'h0C, 8'h00);
        exp_pin(0, 1, "R2 active low pending");
        write(8'h0D, 8'h0C);
        exp_pin(1, 1, "R10 no pending after clear");

        // unmapped addresses
        exp_read(8'h0E, 8'h00, "R9 unmapped read 0E");
        exp_read(8'hFF, 8'h00, "R9 unmapped read FF");
        write(8'h0B, 8'hFF);
        exp_read(8'h0C, 8'h00, "R9 unmapped write leaves cfg");
        exp_read(8'h0D, 8'h00, "R9 unmapped write leaves status");

        // R7 collision: clear lands on the edge that sets the bit
        @(negedge clk);
        cmos_vld[0] = ~cmos_vld[0];
        @(negedge clk);
        @(negedge clk);
        reg_addr  = 8'h0D;
        reg_wdata = 8'h04;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
        exp_read(8'h0D, 8'h04, "R7 set wins over clear");
        write(8'h0D, 8'h04);
        exp_read(8'h0D, 8'h00, "R7 control clear without toggle");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule